// File: doc/BRIEF.md
# MMU Access Permission Checker and Fault Recorder

This block sits at the end of a page-table walk. It receives the final page entry's 3-bit permission field and modified bit, or a walk-fault indication, together with the kind of access (data read, data write, instruction fetch) and the privilege of the requester. In the same cycle it decides whether the access may proceed. It then produces an error code, the read and write protection that a TLB may install, and a trap request.

Each fault is logged in two registers. The status register packs the access index, the error code, a valid bit and an overflow marker. The overflow marker shows that a second fault arrived before software read the first one. The address register keeps the faulting virtual address. Software reads the status through a strobe, and the strobe clears the register on the next cycle. A no-fault control bit or a cleared trap-enable flag suppresses the trap, but the registers are still updated. Trap vectoring is done elsewhere.

Top module: `mmu_perm_fault`

## Requirements
- R1: The access index is {acc_write, acc_exec, supervisor}, where supervisor = !acc_user. A recorded fault stores it in fsr_q[7:5].
- R2: A user access (acc_user=1) to a page whose permission is 6 or 7 gives error code 3 (privilege violation), unless there is a walk fault.
- R3: Without a walk fault, the error code is 2 when the needed right is missing and 0 otherwise. A write (acc_write=1) needs write rights, a fetch (acc_exec=1) needs execute rights, and an access with both bits set needs both. An access with neither bit set needs read rights. Read rights: user 0,1,2,3,5; supervisor all values except 4. Write rights: user 1,3; supervisor 1,3,5,7. Execute rights: user 2,3,4; supervisor 2,3,4,6,7.
- R4: prot_rd is 1 exactly when chk_valid=1 and there is no fault. prot_wr additionally needs pte_modified=1 and write rights for the requester's privilege (user: 1,3; supervisor: 1,3,5,7).
- R5: When walk_fault=1 with chk_valid=1, err_code equals walk_type, both protection outputs are 0, and a fault is recorded.
- R6: A fault is chk_valid with walk_fault=1 or a nonzero error code. On a fault, the next fsr_q is (1 if the old status was nonzero and not being read, else 0) ORed with (index<<5)|(error<<2)|2. fsr_q[0] is therefore the overflow marker.
- R7: On a fault, far_q captures vaddr on the next clock edge.
- R8: trap_req is high in the same cycle as a fault, and only then, when trap_en=1 and ctl_no_fault=0. A suppressed trap still updates fsr_q and far_q.
- R9: stat_rd=1 with no fault clears fsr_q on the next cycle. With a fault in the same cycle, the old status counts as read, so no overflow is marked.
- R10: With chk_valid=0, err_code, prot_rd, prot_wr and trap_req are 0. fsr_q and far_q hold unless stat_rd is high.
- R11: Reset (rst_n low) clears fsr_q and far_q to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | A walk result is presented this cycle |
| acc_write | input | 1 | Access is a write |
| acc_exec | input | 1 | Access is an instruction fetch |
| acc_user | input | 1 | Requester is in user mode |
| pte_perm | input | 3 | Permission field of the final page entry |
| pte_modified | input | 1 | Modified bit of the final page entry |
| walk_fault | input | 1 | The walk itself failed |
| walk_type | input | 3 | Error code supplied with a walk fault |
| vaddr | input | ADDR_W | Virtual address of the access |
| ctl_no_fault | input | 1 | No-fault control bit: suppresses the trap |
| trap_en | input | 1 | Trap-enable flag |
| stat_rd | input | 1 | Software read strobe for the status register |
| trap_req | output | 1 | Single-cycle trap request |
| err_code | output | 3 | Error code of the current check |
| prot_rd | output | 1 | Read permission for the TLB |
| prot_wr | output | 1 | Write permission for the TLB |
| fsr_q | output | 8 | Fault status register |
| far_q | output | ADDR_W | Fault address register |

## Verification
The hardest case to reach is the overflow marker together with its interaction with the read strobe. It needs a fault while the status is still nonzero, and then a fault that falls in the same cycle as a read, where the old value must not count as overflow. Seeded random stimulus keeps the read strobe rare compared with faults, so back-to-back faults happen often. Directed sequences then force the read-and-fault collision, a suppressed trap, and the supervisor-write versus unmodified-page cases.

// File: rtl/mmu_pc_pkg.sv
`timescale 1ns/1ps
package mmu_pc_pkg;
    localparam int PERM_W = 3;
    localparam int ERR_W  = 3;
    localparam int IDX_W  = 3;
    localparam int FSR_W  = IDX_W + ERR_W + 2;
    localparam int IDX_LSB = ERR_W + 2;
    localparam int ERR_LSB = 2;

    localparam logic [ERR_W-1:0] ERR_NONE = 3'd0;
    localparam logic [ERR_W-1:0] ERR_PROT = 3'd2;
    localparam logic [ERR_W-1:0] ERR_PRIV = 3'd3;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } rights_t;

    // Rights granted by a permission value at a given privilege.
    function automatic rights_t perm_rights(input logic [PERM_W-1:0] perm,
                                            input logic sup);
        rights_t r;
        r.rd = sup ? (perm != 3'd4) : (perm <= 3'd3 || perm == 3'd5);
        r.wr = perm[0] && (sup || !perm[2]);
        r.ex = sup ? (perm >= 3'd2) && (perm != 3'd5)
                   : (perm >= 3'd2) && (perm <= 3'd4);
        return r;
    endfunction
endpackage

// File: rtl/mmu_perm_check.sv
`timescale 1ns/1ps
module mmu_perm_check
    import mmu_pc_pkg::*;
(
    input  logic              valid,
    input  logic              is_wr,
    input  logic              is_ex,
    input  logic              is_user,
    input  logic [PERM_W-1:0] perm,
    input  logic              modified,
    input  logic              walk_fault,
    input  logic [ERR_W-1:0]  walk_type,
    output logic [IDX_W-1:0]  acc_idx,
    output logic [ERR_W-1:0]  err,
    output logic              fault,
    output logic              grant_rd,
    output logic              grant_wr
);
    rights_t rights;
    logic    sup;
    logic    need_ok;
    logic    priv_bad;

    always_comb begin
        sup      = !is_user;
        acc_idx  = {is_wr, is_ex, sup};
        rights   = perm_rights(perm, sup);
        priv_bad = is_user && (perm[2:1] == 2'b11);
        if (!is_wr && !is_ex)
            need_ok = rights.rd;
        else
            need_ok = (!is_wr || rights.wr) && (!is_ex || rights.ex);

        err = ERR_NONE;
        if (valid) begin
            if (walk_fault)    err = walk_type;
            else if (priv_bad) err = ERR_PRIV;
            else if (!need_ok) err = ERR_PROT;
        end
        fault    = valid && (walk_fault || err != ERR_NONE);
        grant_rd = valid && !fault;
        grant_wr = grant_rd && modified && rights.wr;
    end
endmodule

// File: rtl/mmu_fault_rec.sv
`timescale 1ns/1ps
module mmu_fault_rec
    import mmu_pc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [ERR_W-1:0]  err,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic              stat_rd,
    output logic [FSR_W-1:0]  fsr,
    output logic [ADDR_W-1:0] far
);
    typedef struct packed {
        logic [FSR_W-1:0]  fsr;
        logic [ADDR_W-1:0] far;
    } rec_t;

    rec_t rec_d, rec_q;
    logic [FSR_W-1:0] base;

    always_comb begin
        rec_d = rec_q;
        base  = stat_rd ? '0 : rec_q.fsr;
        if (fault) begin
            rec_d.fsr = {{(FSR_W-1){1'b0}}, (base != '0)};
            rec_d.fsr[IDX_LSB +: IDX_W] = acc_idx;
            rec_d.fsr[ERR_LSB +: ERR_W] = err;
            rec_d.fsr[1] = 1'b1;
            rec_d.far = vaddr;
        end else if (stat_rd) begin
            rec_d.fsr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign fsr = rec_q.fsr;
    assign far = rec_q.far;
endmodule

// File: rtl/mmu_perm_fault.sv
`timescale 1ns/1ps
module mmu_perm_fault
    import mmu_pc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_valid,
    input  logic              acc_write,
    input  logic              acc_exec,
    input  logic              acc_user,
    input  logic [2:0]        pte_perm,
    input  logic              pte_modified,
    input  logic              walk_fault,
    input  logic [2:0]        walk_type,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic              ctl_no_fault,
    input  logic              trap_en,
    input  logic              stat_rd,
    output logic              trap_req,
    output logic [2:0]        err_code,
    output logic              prot_rd,
    output logic              prot_wr,
    output logic [7:0]        fsr_q,
    output logic [ADDR_W-1:0] far_q
);
    logic [IDX_W-1:0] acc_idx;
    logic             fault;

    mmu_perm_check u_check (
        .valid      (chk_valid),
        .is_wr      (acc_write),
        .is_ex      (acc_exec),
        .is_user    (acc_user),
        .perm       (pte_perm),
        .modified   (pte_modified),
        .walk_fault (walk_fault),
        .walk_type  (walk_type),
        .acc_idx    (acc_idx),
        .err        (err_code),
        .fault      (fault),
        .grant_rd   (prot_rd),
        .grant_wr   (prot_wr)
    );

    mmu_fault_rec #(.ADDR_W(ADDR_W)) u_rec (
        .clk     (clk),
        .rst_n   (rst_n),
        .fault   (fault),
        .acc_idx (acc_idx),
        .err     (err_code),
        .vaddr   (vaddr),
        .stat_rd (stat_rd),
        .fsr     (fsr_q),
        .far     (far_q)
    );

    assign trap_req = fault && trap_en && !ctl_no_fault;
endmodule

// File: rtl/mmu_perm_fault_chk.sv
`timescale 1ns/1ps
module mmu_perm_fault_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chk_valid,
    input logic              acc_user,
    input logic [2:0]        pte_perm,
    input logic              pte_modified,
    input logic              walk_fault,
    input logic [ADDR_W-1:0] vaddr,
    input logic              ctl_no_fault,
    input logic              trap_en,
    input logic              stat_rd,
    input logic              trap_req,
    input logic [2:0]        err_code,
    input logic              prot_wr,
    input logic [7:0]        fsr_q,
    input logic [ADDR_W-1:0] far_q
);
    logic flt;
    assign flt = chk_valid && (walk_fault || err_code != 3'd0);

    assert_priv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && acc_user && !walk_fault && pte_perm[2:1] == 2'b11) |-> err_code == 3'd3);

    assert_wr_needs_mod_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prot_wr |-> (pte_modified && chk_valid && err_code == 3'd0));

    assert_fault_logged_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flt |=> fsr_q[1]);

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flt && fsr_q != 8'd0 && !stat_rd) |=> fsr_q[0]);

    assert_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flt |=> far_q == $past(vaddr));

    assert_trap_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (flt && trap_en && !ctl_no_fault));

    assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !flt) |=> fsr_q == 8'd0);

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_valid && !stat_rd) |=> ($stable(fsr_q) && $stable(far_q)));
endmodule

bind mmu_perm_fault mmu_perm_fault_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .chk_valid    (chk_valid),
    .acc_user     (acc_user),
    .pte_perm     (pte_perm),
    .pte_modified (pte_modified),
    .walk_fault   (walk_fault),
    .vaddr        (vaddr),
    .ctl_no_fault (ctl_no_fault),
    .trap_en      (trap_en),
    .stat_rd      (stat_rd),
    .trap_req     (trap_req),
    .err_code     (err_code),
    .prot_wr      (prot_wr),
    .fsr_q        (fsr_q),
    .far_q        (far_q)
);

// File: tb/mmu_perm_fault_tb.sv
`timescale 1ns/1ps
module mmu_perm_fault_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        chk_valid, acc_write, acc_exec, acc_user;
    logic [2:0]  pte_perm;
    logic        pte_modified, walk_fault;
    logic [2:0]  walk_type;
    logic [31:0] vaddr;
    logic        ctl_no_fault, trap_en, stat_rd;
    logic        trap_req, prot_rd, prot_wr;
    logic [2:0]  err_code;
    logic [7:0]  fsr_q;
    logic [31:0] far_q;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0]  m_fsr;
    logic [31:0] m_far;

    always #5 clk = ~clk;

    mmu_perm_fault #(.ADDR_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .acc_write(acc_write),
        .acc_exec(acc_exec), .acc_user(acc_user), .pte_perm(pte_perm),
        .pte_modified(pte_modified), .walk_fault(walk_fault), .walk_type(walk_type),
        .vaddr(vaddr), .ctl_no_fault(ctl_no_fault), .trap_en(trap_en),
        .stat_rd(stat_rd), .trap_req(trap_req), .err_code(err_code),
        .prot_rd(prot_rd), .prot_wr(prot_wr), .fsr_q(fsr_q), .far_q(far_q)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit rd_ok(input bit u, input logic [2:0] p);
        return u ? (p == 0 || p == 1 || p == 2 || p == 3 || p == 5) : (p != 4);
    endfunction
    function automatic bit wr_ok(input bit u, input logic [2:0] p);
        return u ? (p == 1 || p == 3) : (p == 1 || p == 3 || p == 5 || p == 7);
    endfunction
    function automatic bit ex_ok(input bit u, input logic [2:0] p);
        return u ? (p == 2 || p == 3 || p == 4) : (p == 2 || p == 3 || p == 4 || p == 6 || p == 7);
    endfunction
    function automatic logic [2:0] exp_err(input bit w, input bit x, input bit u,
                                           input logic [2:0] p);
        bit ok;
        if (u && p >= 6) return 3'd3;
        if (!w && !x) ok = rd_ok(u, p);
        else ok = (!w || wr_ok(u, p)) && (!x || ex_ok(u, p));
        return ok ? 3'd0 : 3'd2;
    endfunction

    // Drives one cycle at a falling edge, checks combinational outputs,
    // then checks the registers at the next falling edge.
    task automatic apply(input bit v, input bit w, input bit x, input bit u,
                         input logic [2:0] p, input bit md, input bit wf,
                         input logic [2:0] wt, input logic [31:0] a,
                         input bit nf, input bit te, input bit rd, input string rtag);
        logic [2:0] e;
        logic [2:0] idx;
        logic [7:0] base;
        bit flt;
        string tag;
        chk_valid = v; acc_write = w; acc_exec = x; acc_user = u; pte_perm = p;
        pte_modified = md; walk_fault = wf; walk_type = wt; vaddr = a;
        ctl_no_fault = nf; trap_en = te; stat_rd = rd;
        #1;
        idx = {w, x, !u};
        e = !v ? 3'd0 : (wf ? wt : exp_err(w, x, u, p));
        flt = v && (wf || e != 0);
        tag = !v ? "R10" : wf ? "R5" : (u && p >= 6) ? "R2" : "R3";
        chk(err_code == e, tag, "err_code", 32'(err_code), 32'(e));
        chk(prot_rd == (v && !flt), v ? "R4" : "R10", "prot_rd", 32'(prot_rd), 32'(v && !flt));
        chk(prot_wr == (v && !flt && md && wr_ok(u, p)), v ? "R4" : "R10", "prot_wr",
            32'(prot_wr), 32'(v && !flt && md && wr_ok(u, p)));
        chk(trap_req == (flt && te && !nf), "R8", "trap_req", 32'(trap_req), 32'(flt && te && !nf));
        base = rd ? 8'd0 : m_fsr;
        if (flt) begin
            m_fsr = {idx, e, 2'b10} | {7'd0, (base != 0)};
            m_far = a;
        end else if (rd) m_fsr = 8'd0;
        @(negedge clk);
        chk(fsr_q == m_fsr, rtag, "fsr_q", 32'(fsr_q), 32'(m_fsr));
        chk(far_q == m_far, flt ? "R7" : rtag, "far_q", far_q, m_far);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        chk_valid = 0; acc_write = 0; acc_exec = 0; acc_user = 0; pte_perm = 0;
        pte_modified = 0; walk_fault = 0; walk_type = 0; vaddr = 0;
        ctl_no_fault = 0; trap_en = 1; stat_rd = 0;
        m_fsr = 0; m_far = 0;
        repeat (3) @(negedge clk);
        chk(fsr_q == 0, "R11", "fsr_q reset", 32'(fsr_q), 0);
        chk(far_q == 0, "R11", "far_q reset", far_q, 0);
        rst_n = 1'b1;

        // R1: user write to perm 4 -> error 2, index {1,0,0}
        apply(1, 1, 0, 1, 3'd4, 0, 0, 0, 32'hCAFE_0004, 0, 1, 0, "R6");
        chk(fsr_q[7:5] == 3'b100, "R1", "fsr index", 32'(fsr_q[7:5]), 32'd4);
        // second fault without read -> overflow marker
        apply(1, 0, 0, 1, 3'd6, 0, 0, 0, 32'h1000_0010, 0, 1, 0, "R6");
        chk(fsr_q[0] == 1'b1, "R6", "overflow bit", 32'(fsr_q[0]), 1);
        // fault colliding with read: no overflow
        apply(1, 0, 1, 0, 3'd0, 0, 0, 0, 32'h2000_0020, 0, 1, 1, "R9");
        chk(fsr_q[0] == 1'b0, "R9", "no overflow on read", 32'(fsr_q[0]), 0);
        // plain read clears
        apply(0, 0, 0, 0, 3'd0, 0, 0, 0, 32'h0, 0, 1, 1, "R9");
        // idle holds
        apply(0, 1, 1, 1, 3'd7, 1, 1, 3'd5, 32'hFFFF_FFFF, 0, 1, 0, "R10");
        // suppressed trap still logs
        apply(1, 0, 0, 0, 3'd0, 0, 1, 3'd5, 32'h3000_0030, 1, 1, 0, "R8");
        apply(1, 0, 0, 1, 3'd1, 0, 1, 3'd1, 32'h3000_0034, 0, 0, 0, "R8");
        // user fetch from perm 4 ok; supervisor write perm 7 modified / clean
        apply(1, 0, 1, 1, 3'd4, 1, 0, 0, 32'h4000_0040, 0, 1, 0, "R3");
        apply(1, 1, 0, 0, 3'd7, 1, 0, 0, 32'h5000_0050, 0, 1, 0, "R4");
        apply(1, 1, 0, 0, 3'd7, 0, 0, 0, 32'h5000_0054, 0, 1, 0, "R4");
        apply(1, 1, 1, 0, 3'd7, 1, 0, 0, 32'h5000_0058, 0, 1, 1, "R9");

        for (int i = 0; i < 3000; i++) begin
            bit v, w, x, u, md, wf, nf, te, rd;
            logic [2:0] p, wt;
            v  = ($urandom % 10) < 7;
            w  = $urandom % 2;  x  = $urandom % 2;  u  = $urandom % 2;
            p  = 3'($urandom);  md = $urandom % 2;
            wf = ($urandom % 8) == 0; wt = 3'($urandom);
            nf = ($urandom % 6) == 0; te = ($urandom % 6) != 0;
            rd = ($urandom % 5) == 0;
            apply(v, w, x, u, p, md, wf, wt, $urandom, nf, te, rd, "R6");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule